// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that software drives through a five-entry register file. A receiver turns the serial input line into characters by oversampling it with an externally supplied tick. It checks the optional parity bit and the stop bit, and it places each finished character in a receive holding register. A transmitter takes a character from a transmit holding register, frames it and shifts it out. Each direction raises a one-cycle completion interrupt. The shift registers themselves cannot be reached from the bus.

The oversampling tick `os_tick` must pulse sixteen times per bit period. The transmitter divides it by sixteen to get its bit clock. Register offsets are 0 mode, 1 receive-error flags, 2 transmit flags, 3 receive holding and 4 transmit holding. Reads are registered, so `rdata` is valid the cycle after `rd_en`.

Top module: `serial_port_top`

## Requirements
- R1: After a synchronous reset every register reads 0, `txd` is 1 and both interrupt outputs are 0.
- R2: A write to offset 0 stores the mode in bits [5:0] and reads back unchanged one cycle after `rd_en`. The mode bits are: bit0 transmit on, bit1 receive on, bits[3:2] parity (0 none, 1 even, 2 odd, 3 always-zero), bit4 seven-bit characters, bit5 two stop bits.
- R3: The receiver confirms a start bit at its midpoint and samples each data bit at its centre, LSB first, with 16 ticks per bit. The character enters the holding register (offset 3) only when the stop bit is sampled. `rx_irq` pulses for one cycle as the character becomes readable.
- R4: In seven-bit mode exactly seven data bits are received, and bit 7 of the holding register is 0.
- R5: When parity is on, the receiver compares the parity bit against the selected rule. A mismatch sets bit0 of offset 1.
- R6: A stop bit sampled low sets bit1 of offset 1. The character is still stored.
- R7: A character that completes while the previous one was never read at offset 3 sets bit2 of offset 1. The newer character replaces the older one.
- R8: A read of offset 1 returns the error flags and clears them, so an immediate second read returns 0.
- R9: The transmitter sends a low start bit, the data bits LSB first (7 or 8), the parity bit if enabled, then one or two high stop bits. Each bit lasts 16 ticks.
- R10: Offset 2 bit0 is 1 while the transmit holding register holds a character not yet taken. Bit1 is 1 while a frame is being shifted. A held character is taken at the next bit clock when the shifter is idle, which clears bit0.
- R11: `tx_irq` pulses for one cycle when the last stop bit of a frame has ended.
- R12: With receive off, line activity stores nothing and raises no interrupt. With transmit off, a written character stays held and the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| rx_irq | output | 1 | Receive-complete pulse |
| tx_irq | output | 1 | Transmit-complete pulse |

## Verification
The hardest conditions to reach from the ports are the overrun and framing errors. The overrun case needs two complete frames to arrive with no read of the holding register between them. The stimulus sends them back to back and only then reads the flags and the buffer. A low stop bit can make the receiver see a false start edge. To keep that from turning into a phantom frame, the bench holds the stop bit low only past its sampling point and then releases the line.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_ZERO = 2'd3
  } par_e;

  typedef struct packed {
    logic two_stop;
    logic char7;
    par_e par;
    logic rx_on;
    logic tx_on;
  } mode_t;

  localparam logic [2:0] OFS_MODE  = 3'd0;
  localparam logic [2:0] OFS_RXERR = 3'd1;
  localparam logic [2:0] OFS_TXST  = 3'd2;
  localparam logic [2:0] OFS_RXBUF = 3'd3;
  localparam logic [2:0] OFS_TXBUF = 3'd4;

  function automatic logic par_bit(par_e p, logic x);
    case (p)
      PAR_EVEN: return x;
      PAR_ODD:  return ~x;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          en,
  input  logic          char7,
  input  par_e          par,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          ferr
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_e;
  st_e st;
  logic [1:0]    sync;
  logic          line;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn, last;
  logic [DW-1:0] sh;
  logic          xr, perr_q;
  logic          mid;

  assign line = sync[1];
  assign last = char7 ? BW'(DW-2) : BW'(DW-1);
  assign mid  = (cnt == CW'(OVS-1));

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sh <= '0; xr <= 1'b0; perr_q <= 1'b0;
      done <= 1'b0; data <= '0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) st <= S_IDLE;
      else if (tick) begin
        case (st)
          S_IDLE: if (!line) begin st <= S_START; cnt <= '0; end
          S_START:
            if (cnt == CW'(OVS/2-1)) begin
              if (!line) begin
                st <= S_DATA; cnt <= '0; bitn <= '0; xr <= 1'b0; perr_q <= 1'b0;
              end else st <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          S_DATA:
            if (mid) begin
              cnt <= '0;
              sh  <= {line, sh[DW-1:1]};
              xr  <= xr ^ line;
              if (bitn == last) st <= (par == PAR_NONE) ? S_STOP : S_PAR;
              else bitn <= bitn + 1'b1;
            end else cnt <= cnt + 1'b1;
          S_PAR:
            if (mid) begin
              cnt <= '0;
              perr_q <= (line != par_bit(par, xr));
              st <= S_STOP;
            end else cnt <= cnt + 1'b1;
          S_STOP:
            if (mid) begin
              done <= 1'b1;
              ferr <= ~line;
              perr <= perr_q;
              data <= char7 ? {1'b0, sh[DW-1:1]} : sh;
              st   <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  rx_done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R12
  rx_off_quiet_chk: assert property (@(posedge clk) disable iff (rst) !en |=> !done);
  // R4
  rx_pad_zero_chk: assert property (@(posedge clk) disable iff (rst) (done && char7) |-> !data[DW-1]);
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          char7,
  input  par_e          par,
  input  logic          two_stop,
  input  logic          req,
  input  logic [DW-1:0] din,
  output logic          take,
  output logic          busy,
  output logic          txd,
  output logic          done
);
  localparam int CW = $clog2(OVS);
  localparam int FW = DW + 4;
  localparam int LW = $clog2(FW + 1);

  logic [CW-1:0] div;
  logic          bit_tick;
  logic [FW-1:0] frame, sh;
  logic [LW-1:0] flen, rem;

  assign bit_tick = tick && (div == CW'(OVS-1));

  always_comb begin
    int nd;
    logic [DW-1:0] mask;
    nd    = char7 ? DW-1 : DW;
    mask  = char7 ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i < nd) frame[1+i] = din[i];
    if (par != PAR_NONE) frame[1+nd] = par_bit(par, ^(din & mask));
    flen = LW'(1 + nd + ((par != PAR_NONE) ? 1 : 0) + (two_stop ? 2 : 1));
  end

  always_ff @(posedge clk) begin
    if (rst) div <= '0;
    else if (tick) div <= div + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '1; rem <= '0; busy <= 1'b0; txd <= 1'b1; take <= 1'b0; done <= 1'b0;
    end else begin
      take <= 1'b0;
      done <= 1'b0;
      if (bit_tick) begin
        if (!busy) begin
          if (req && en) begin
            sh <= frame; rem <= flen; txd <= frame[0]; busy <= 1'b1; take <= 1'b1;
          end
        end else if (rem == LW'(1)) begin
          busy <= 1'b0; txd <= 1'b1; done <= 1'b1;
        end else begin
          sh <= sh >> 1; txd <= sh[1]; rem <= rem - 1'b1;
        end
      end
    end
  end

  // R9
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> txd);
  // R11
  tx_done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  tx_take_held_chk: assert property (@(posedge clk) disable iff (rst) take |-> busy);
endmodule

// File: rtl/serial_port_top.sv
module serial_port_top
  import sio_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          rxd,
  output logic          txd,
  output logic          rx_irq,
  output logic          tx_irq
);
  mode_t         mode_q;
  logic [DW-1:0] rx_buf, tx_buf;
  logic          rx_unread, tx_full;
  logic [2:0]    err_q;
  logic          rx_done, rx_perr, rx_ferr;
  logic [DW-1:0] rx_data;
  logic          tx_take, tx_busy, tx_done;
  logic          rd_buf, rd_err;

  assign rd_buf = rd_en && (addr == OFS_RXBUF);
  assign rd_err = rd_en && (addr == OFS_RXERR);

  sio_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(os_tick), .rxd(rxd),
    .en(mode_q.rx_on), .char7(mode_q.char7), .par(mode_q.par),
    .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );

  sio_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(os_tick),
    .en(mode_q.tx_on), .char7(mode_q.char7), .par(mode_q.par), .two_stop(mode_q.two_stop),
    .req(tx_full), .din(tx_buf),
    .take(tx_take), .busy(tx_busy), .txd(txd), .done(tx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; tx_buf <= '0; tx_full <= 1'b0;
    end else begin
      if (tx_take) tx_full <= 1'b0;
      if (wr_en) begin
        case (addr)
          OFS_MODE:  mode_q <= mode_t'(wdata[5:0]);
          OFS_TXBUF: begin tx_buf <= wdata; tx_full <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf <= '0; rx_unread <= 1'b0; err_q <= '0; rx_irq <= 1'b0; tx_irq <= 1'b0;
    end else begin
      rx_irq <= rx_done;
      tx_irq <= tx_done;
      if (rd_err) err_q <= '0;
      if (rd_buf) rx_unread <= 1'b0;
      if (rx_done) begin
        rx_buf    <= rx_data;
        rx_unread <= 1'b1;
        err_q     <= (rd_err ? 3'b000 : err_q) |
                     {rx_unread && !rd_buf, rx_ferr, rx_perr};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        OFS_MODE:  rdata <= DW'(mode_q);
        OFS_RXERR: rdata <= DW'(err_q);
        OFS_TXST:  rdata <= DW'({tx_busy, tx_full});
        OFS_RXBUF: rdata <= rx_buf;
        default:   rdata <= '0;
      endcase
    end
  end

  // R3
  rx_irq_unread_chk: assert property (@(posedge clk) disable iff (rst) rx_irq |-> rx_unread);
  // R3
  rx_irq_single_chk: assert property (@(posedge clk) disable iff (rst) rx_irq |=> !rx_irq);
  // R11
  tx_irq_single_chk: assert property (@(posedge clk) disable iff (rst) tx_irq |=> !tx_irq);
  // R10
  tx_take_full_chk: assert property (@(posedge clk) disable iff (rst) tx_take |-> $past(tx_full));
  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_err && !rx_done) |=> (err_q == 3'b000));
endmodule

// File: tb/serial_port_top_tb.sv
module serial_port_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rxd = 1'b1;
  logic txd, rx_irq, tx_irq;

  int n_cmp = 0, n_bad = 0;
  int rx_cnt = 0, tx_cnt = 0, frames_done = 0;
  bit finished = 0;

  typedef struct { logic [7:0] d; int nb; int pm; int ns; } txexp_t;
  txexp_t txq[$];

  always #5 clk = ~clk;

  serial_port_top u_dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd),
    .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  always @(negedge clk) os_tick <= ~os_tick;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  function automatic logic pbit(logic [7:0] d, int nb, int pm);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    if (pm == 1) return x;
    if (pm == 2) return ~x;
    return 1'b0;
  endfunction

  function automatic int build(txexp_t e, output logic [11:0] bits);
    int k = 0;
    bits = '1;
    bits[k++] = 1'b0;
    for (int i = 0; i < e.nb; i++) bits[k++] = e.d[i];
    if (e.pm != 0) bits[k++] = pbit(e.d, e.nb, e.pm);
    return k + e.ns;
  endfunction

  task automatic send_rx(logic [7:0] d, int nb, int pm, bit badpar, bit stop_ok);
    @(negedge clk); rxd = 1'b0; repeat (32) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; repeat (32) @(negedge clk); end
    if (pm != 0) begin rxd = pbit(d, nb, pm) ^ badpar; repeat (32) @(negedge clk); end
    if (stop_ok) begin rxd = 1'b1; repeat (32) @(negedge clk); end
    else begin rxd = 1'b0; repeat (26) @(negedge clk); rxd = 1'b1; end
    repeat (64) @(negedge clk);
  endtask

  task automatic wait_tx(int n);
    for (int i = 0; i < 3000 && tx_cnt < n; i++) @(negedge clk);
  endtask

  always @(negedge clk) if (!rst && rx_irq) rx_cnt++;

  // R11: the completion pulse follows the decoded end of frame
  always @(negedge clk) if (!rst && tx_irq) begin
    tx_cnt++;
    chk("R11 pulse after frame", int'(frames_done >= tx_cnt), 1);
  end

  // Scoreboard monitor for the serial output (R9)
  always begin
    @(negedge clk);
    if (!rst && txd === 1'b0) begin
      txexp_t e;
      logic [11:0] expb, obs;
      int len;
      if (txq.size() == 0) begin
        chk("R12 unexpected tx frame", 1, 0);
        while (txd !== 1'b1) @(negedge clk);
      end else begin
        e = txq.pop_front();
        len = build(e, expb);
        obs = '1;
        repeat (16) @(negedge clk);
        obs[0] = txd;
        for (int k = 1; k < len; k++) begin repeat (32) @(negedge clk); obs[k] = txd; end
        chk("R9 tx frame bits", int'(obs), int'(expb));
        frames_done++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 txd idle", int'(txd), 1);
    chk("R1 irqs", int'({rx_irq, tx_irq}), 0);
    rd(3'd0, v); chk("R1 mode", v, 0);
    rd(3'd1, v); chk("R1 rx err", v, 0);
    rd(3'd2, v); chk("R1 tx status", v, 0);
    rd(3'd3, v); chk("R1 rx buffer", v, 0);
    // R2
    wr(3'd0, 8'h03); rd(3'd0, v); chk("R2 mode readback", v, 8'h03);
    wr(3'd0, 8'h3B); rd(3'd0, v); chk("R2 mode readback all fields", v, 8'h3B);
    wr(3'd0, 8'h03);
    // R3 8N1
    send_rx(8'hA5, 8, 0, 0, 1);
    chk("R3 rx irq count", rx_cnt, 1);
    rd(3'd3, v); chk("R3 rx data", v, 8'hA5);
    rd(3'd1, v); chk("R5 no error", v, 0);
    // R4 seven-bit even parity
    wr(3'd0, 8'h17);
    send_rx(8'h3C, 7, 1, 0, 1);
    rd(3'd3, v); chk("R4 seven-bit data", v, 8'h3C);
    send_rx(8'hFF, 7, 1, 0, 1);
    rd(3'd3, v); chk("R4 msb padded zero", v, 8'h7F);
    rd(3'd1, v); chk("R5 even parity ok", v, 0);
    // R5 odd parity mismatch, R8 clear on read
    wr(3'd0, 8'h0B);
    send_rx(8'h81, 8, 2, 1, 1);
    rd(3'd3, v); chk("R5 data with bad parity", v, 8'h81);
    rd(3'd1, v); chk("R5 parity flag", v, 8'h01);
    rd(3'd1, v); chk("R8 cleared by read", v, 0);
    // R5 always-zero parity
    wr(3'd0, 8'h0F);
    send_rx(8'h00, 8, 3, 1, 1);
    rd(3'd3, v);
    rd(3'd1, v); chk("R5 zero parity mismatch", v, 8'h01);
    send_rx(8'h5A, 8, 3, 0, 1);
    rd(3'd3, v); chk("R5 zero parity data", v, 8'h5A);
    rd(3'd1, v); chk("R5 zero parity ok", v, 0);
    // R6 framing
    wr(3'd0, 8'h03);
    base = rx_cnt;
    send_rx(8'h33, 8, 0, 0, 0);
    chk("R6 single frame", rx_cnt - base, 1);
    rd(3'd1, v); chk("R6 framing flag", v, 8'h02);
    rd(3'd3, v); chk("R6 data kept", v, 8'h33);
    // R7 overrun
    send_rx(8'h11, 8, 0, 0, 1);
    send_rx(8'h22, 8, 0, 0, 1);
    rd(3'd1, v); chk("R7 overrun flag", v, 8'h04);
    rd(3'd3, v); chk("R7 newer data", v, 8'h22);
    // R12 receive off
    wr(3'd0, 8'h01);
    base = rx_cnt;
    send_rx(8'h44, 8, 0, 0, 1);
    chk("R12 no rx irq", rx_cnt - base, 0);
    rd(3'd3, v); chk("R12 rx buffer unchanged", v, 8'h22);
    // R10/R12 transmit off holds data
    wr(3'd0, 8'h02);
    wr(3'd4, 8'h96);
    repeat (100) @(negedge clk);
    rd(3'd2, v); chk("R12 held while tx off", v, 8'h01);
    chk("R12 line idle", int'(txd), 1);
    txq.push_back('{d: 8'h96, nb: 8, pm: 0, ns: 1});
    wr(3'd0, 8'h03);
    repeat (40) @(negedge clk);
    rd(3'd2, v); chk("R10 taken and shifting", v, 8'h02);
    txq.push_back('{d: 8'h3B, nb: 8, pm: 0, ns: 1});
    wr(3'd4, 8'h3B);
    rd(3'd2, v); chk("R10 held and shifting", v, 8'h03);
    wait_tx(2);
    chk("R11 two completions", tx_cnt, 2);
    // R9 seven-bit odd two stop
    txq.push_back('{d: 8'h4D, nb: 7, pm: 2, ns: 2});
    wr(3'd0, 8'h3B);
    wr(3'd4, 8'h4D);
    wait_tx(3);
    chk("R11 third completion", tx_cnt, 3);
    // R9 eight-bit zero parity
    txq.push_back('{d: 8'hFF, nb: 8, pm: 3, ns: 1});
    wr(3'd0, 8'h0F);
    wr(3'd4, 8'hFF);
    wait_tx(4);
    repeat (40) @(negedge clk);
    chk("R9 all frames seen", frames_done, 4);
    rd(3'd2, v); chk("R10 idle status", v, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule